// File: doc/BRIEF.md
# Privilege Mode and Segment Checker

This block sits in front of address translation in a processor's memory pipeline. From the current status word it works out the privilege level the core runs at. It then sorts each access address into one of two groups: the fixed, directly mapped kernel windows, or the mapped space that must go through a translation lookaside buffer. The lookup itself happens elsewhere.

For the two direct windows, the block forms the physical address at once by stripping the top three address bits. It also flags two kinds of fault: accesses that are not aligned to their size, and accesses to the cached kernel window made from outside kernel mode. When a fault occurs it reports whether the fault belongs to a store, and it keeps the faulting address. A separate flag marks accesses as uncacheable, based on a fixed address pattern.

The checker is combinational. The parameter `REG_OUT` (default 1) places one register stage on every output, with an asynchronous active-low reset. With `REG_OUT` set to 0 the outputs follow the inputs directly.

Top module: `priv_seg_check`

## Requirements
- R1: `mode_o` is 0 (kernel) when any of status bits 28, 2 or 1 is set, or when status bits [4:3] equal 00.
- R2: With none of those override bits set, status bits [4:3] equal to 01 give `mode_o`=1 (supervisor), 10 give 2 (user), and 11 give 3 (invalid).
- R3: Addresses with bits [31:29] equal to 100 or 101 (0x80000000–0xBFFFFFFF) assert `bypass_o`. In that case `paddr_o` is the address with bits [31:29] cleared. Otherwise `bypass_o` and `paddr_o` are 0.
- R4: `xlate_o` is 1 exactly when `bypass_o` is 0.
- R5: An access with `size_i` of 1, 2 or 4 bytes is misaligned when `vaddr_i & (size_i-1)` is nonzero, and a misaligned access raises `addr_err_o`.
- R6: An access in 0x80000000–0x9FFFFFFF raises `addr_err_o` when `mode_o` is not 0. The 0xA0000000–0xBFFFFFFF window never faults on privilege.
- R7: `err_store_o` is 1 when `addr_err_o` is 1 and `kind_i` is 2 (store). Kinds 0 (fetch) and 1 (load) report a fetch/load error with `err_store_o`=0.
- R8: `bad_vaddr_o` carries the access address whenever `addr_err_o` is 1, and is 0 otherwise.
- R9: `uncache_o` is 1 when bits 31 and 29 of the address are both set.
- R10: With `REG_OUT`=1, all outputs are 0 during reset and show the result for the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 32 | Processor status word |
| vaddr_i | input | 32 | Virtual address of the access |
| size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| kind_i | input | 2 | 0 fetch, 1 load, 2 store |
| mode_o | output | 2 | 0 kernel, 1 supervisor, 2 user, 3 invalid |
| bypass_o | output | 1 | Address lies in a direct kernel window |
| paddr_o | output | 32 | Physical address for direct windows |
| xlate_o | output | 1 | Address needs translation |
| addr_err_o | output | 1 | Address error raised |
| err_store_o | output | 1 | The address error belongs to a store |
| bad_vaddr_o | output | 32 | Faulting address, 0 when no error |
| uncache_o | output | 1 | Access is uncacheable |

## Verification
With the default single output stage, every result becomes valid one rising edge after its inputs are applied, and no result needs more than that one edge. The bench applies each vector on a falling edge. It lets one rising edge pass and compares all outputs on the following falling edge, before it drives the next vector. The sweep covers each status mode field combined with each override bit, every value of the top address nibble, each low-order offset, each size and each access kind. Expected values come from plain arithmetic on those inputs.

// File: rtl/priv_seg_check.sv
module priv_seg_check #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] status_i,
  input  logic [31:0] vaddr_i,
  input  logic [2:0]  size_i,
  input  logic [1:0]  kind_i,
  output logic [1:0]  mode_o,
  output logic        bypass_o,
  output logic [31:0] paddr_o,
  output logic        xlate_o,
  output logic        addr_err_o,
  output logic        err_store_o,
  output logic [31:0] bad_vaddr_o,
  output logic        uncache_o
);

  localparam logic [31:0] OVR_MASK = 32'h1000_0006;
  localparam logic [31:0] UNC_MASK = 32'hA000_0000;
  localparam logic [1:0]  KIND_ST  = 2'd2;

  logic [1:0]  mode_c;
  logic        win0_c, win1_c, byp_c, misal_c, err_c;
  logic [31:0] pa_c;

  assign mode_c  = ((status_i & OVR_MASK) != 32'd0) ? 2'd0 : status_i[4:3];
  assign win0_c  = (vaddr_i[31:29] == 3'b100);
  assign win1_c  = (vaddr_i[31:29] == 3'b101);
  assign byp_c   = win0_c | win1_c;
  assign pa_c    = byp_c ? {3'b000, vaddr_i[28:0]} : 32'd0;
  assign misal_c = ((vaddr_i[2:0] & (size_i - 3'd1)) != 3'd0);
  assign err_c   = misal_c | (win0_c & (mode_c != 2'd0));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_o      <= 2'd0;
          bypass_o    <= 1'b0;
          paddr_o     <= 32'd0;
          xlate_o     <= 1'b0;
          addr_err_o  <= 1'b0;
          err_store_o <= 1'b0;
          bad_vaddr_o <= 32'd0;
          uncache_o   <= 1'b0;
        end else begin
          mode_o      <= mode_c;
          bypass_o    <= byp_c;
          paddr_o     <= pa_c;
          xlate_o     <= ~byp_c;
          addr_err_o  <= err_c;
          err_store_o <= err_c & (kind_i == KIND_ST);
          bad_vaddr_o <= err_c ? vaddr_i : 32'd0;
          uncache_o   <= ((vaddr_i & UNC_MASK) == UNC_MASK);
        end
      end

      assert_reg_stage_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bad_vaddr_o == ($past(err_c) ? $past(vaddr_i) : 32'd0)));
      assert_store_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (err_store_o == ($past(kind_i) == KIND_ST && addr_err_o)));
    end else begin : g_comb
      assign mode_o      = mode_c;
      assign bypass_o    = byp_c;
      assign paddr_o     = pa_c;
      assign xlate_o     = ~byp_c;
      assign addr_err_o  = err_c;
      assign err_store_o = err_c & (kind_i == KIND_ST);
      assign bad_vaddr_o = err_c ? vaddr_i : 32'd0;
      assign uncache_o   = ((vaddr_i & UNC_MASK) == UNC_MASK);
    end
  endgenerate

  assert_xlate_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (xlate_o != bypass_o));
  assert_bypass_pa_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_o |-> (paddr_o[31:29] == 3'b000));
  assert_store_has_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_store_o |-> addr_err_o);
  assert_bad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_err_o |-> (bad_vaddr_o == 32'd0));
  assert_nobyp_pa_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_o |-> (paddr_o == 32'd0));

endmodule

// File: tb/priv_seg_check_tb.sv
module priv_seg_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] status_i = '0, vaddr_i = '0;
  logic [2:0]  size_i = 3'd1;
  logic [1:0]  kind_i = '0;
  logic [1:0]  mode_o;
  logic        bypass_o, xlate_o, addr_err_o, err_store_o, uncache_o;
  logic [31:0] paddr_o, bad_vaddr_o;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  priv_seg_check u_dut (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .vaddr_i(vaddr_i),
    .size_i(size_i), .kind_i(kind_i), .mode_o(mode_o), .bypass_o(bypass_o),
    .paddr_o(paddr_o), .xlate_o(xlate_o), .addr_err_o(addr_err_o),
    .err_store_o(err_store_o), .bad_vaddr_o(bad_vaddr_o), .uncache_o(uncache_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (status=%h va=%h sz=%0d k=%0d)",
               req, act, exp, status_i, vaddr_i, size_i, kind_i);
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] ovr [4];
    logic [2:0]  sizes [3];
    ovr[0] = 32'h0; ovr[1] = 32'h2; ovr[2] = 32'h4; ovr[3] = 32'h1000_0000;
    sizes[0] = 3'd1; sizes[1] = 3'd2; sizes[2] = 3'd4;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {30'd0, mode_o}, 32'd0);
    chk("R10", {31'd0, xlate_o}, 32'd0);
    chk("R10", {31'd0, addr_err_o}, 32'd0);
    chk("R10", bad_vaddr_o, 32'd0);
    rst_n = 1'b1;
    for (int f = 0; f < 4; f++)
      for (int o = 0; o < 4; o++)
        for (int nib = 0; nib < 16; nib++)
          for (int off = 0; off < 4; off++)
            for (int s = 0; s < 3; s++)
              for (int k = 0; k < 3; k++) begin
                logic [1:0]  emode;
                logic        ebyp, emis, eerr;
                logic [31:0] va;
                @(negedge clk);
                va = {nib[3:0], 28'h5a3c7f0} | off;
                status_i = ovr[o] | (f << 3) | 32'h00ff_0020;
                vaddr_i = va; size_i = sizes[s]; kind_i = k[1:0];
                emode = (o != 0 || f == 0) ? 2'd0 : f[1:0];
                ebyp  = (nib == 8 || nib == 9 || nib == 10 || nib == 11);
                emis  = (off % sizes[s]) != 0;
                eerr  = emis || ((nib == 8 || nib == 9) && emode != 2'd0);
                @(negedge clk);
                chk((o != 0 || f == 0) ? "R1" : "R2", {30'd0, mode_o}, {30'd0, emode});
                chk("R3", {31'd0, bypass_o}, {31'd0, ebyp});
                chk("R3", paddr_o, ebyp ? (va & 32'h1fff_ffff) : 32'd0);
                chk("R4", {31'd0, xlate_o}, {31'd0, !ebyp});
                chk(emis ? "R5" : "R6", {31'd0, addr_err_o}, {31'd0, eerr});
                chk("R7", {31'd0, err_store_o}, {31'd0, eerr && k == 2});
                chk("R8", bad_vaddr_o, eerr ? va : 32'd0);
                chk("R9", {31'd0, uncache_o}, {31'd0, (nib == 10 || nib == 11 || nib == 14 || nib == 15)});
              end
    // R10: outputs hold the last sampled result while inputs stay put
    @(negedge clk);
    chk("R10", {31'd0, xlate_o}, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule